// File: doc/BRIEF.md
# Queue Tail Doorbell Bank

This block holds the tail pointers of 16 outbound and 16 inbound DMA queues and lets software advance them by writing a descriptor count to a doorbell. Software never computes a new tail. It writes only how many descriptors it has added, and the bank adds that count to the queue's tail. One group of registers serves each direction.

A broadcast doorbell in each direction advances every queue whose bit is set in that direction's 16-bit group mask, all in the same clock cycle, so a transfer spread over several engines starts with one write. The bank has a head-pointer input for every queue and drives that queue's tail and its pending descriptor count (tail minus head) as outputs. A downstream fetch engine can therefore watch how much work each queue holds.

The bus is a single-cycle register port. Writes take effect at the clock edge where the strobe is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `db_bank`

## Requirements
- R1: After reset every tail pointer in both directions is zero, both group masks are zero, and `bus_rdata` is zero.
- R2: A write to address 0x1038 + q*0x1000 (address bit 17 = 0, q = 0..15) adds the write data bits 23:0 to outbound tail q. The new tail is visible on `tail_out_o` from the cycle after the write. No other tail changes.
- R3: A write to address 0x20000 + 0x1038 + q*0x1000 (address bit 17 = 1) adds the write data bits 23:0 to inbound tail q in the same way. No other tail changes.
- R4: Write data bits 31:24 of a doorbell write have no effect on any tail.
- R5: Tail pointers are 24 bits wide and wrap modulo 2^24.
- R6: Reading an outbound queue doorbell returns, in bits 23:0, the last count written directly to that queue's doorbell, with the upper bits zero. Broadcast writes do not change this value. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R7: The inbound queue doorbells are write-only: reading one returns zero.
- R8: Each direction has a 16-bit group mask at group offset 0x000 of group 0 (address 0x00000 outbound, 0x20000 inbound). A write loads it from data bits 15:0, and a read returns it in bits 15:0.
- R9: A write to the broadcast doorbell at group offset 0x038 of group 0 (0x00038 outbound, 0x20038 inbound) adds data bits 23:0 to the tail of every queue of that direction whose mask bit is set, all in the same cycle. Unmasked queues keep their tails.
- R10: For every queue, the pending count output equals its tail minus its head input, modulo 2^24.
- R11: Writes to any other offset or group (for example 0x04000, or group 17 at 0x11038) change no tail and no mask. Reads from such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 18 | Byte address; bit 17 selects inbound, bits 16:12 the group, bits 11:0 the offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| head_out_i | input | 384 | Outbound head pointers, 24 bits per queue, queue 0 in the low bits |
| head_in_i | input | 384 | Inbound head pointers, same packing |
| tail_out_o | output | 384 | Outbound tail pointers |
| pend_out_o | output | 384 | Outbound pending counts |
| tail_in_o | output | 384 | Inbound tail pointers |
| pend_in_o | output | 384 | Inbound pending counts |

## Verification
A wrong tail register shows on the tail and pending outputs in the cycle after the write that produced it. It stays wrong from then on, because every later increment builds on it. A corrupted group mask is not visible until a broadcast is issued or the mask is read back, so the bench reads the masks and fires broadcasts with mixed masks in both directions. A decode fault shows up as a neighbouring queue moving, so after each write the bench compares all 32 tails against its model, not only the queue it targeted.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DB_NQ      = 16;
  localparam int DB_TW      = 24;
  localparam int DB_AW      = 18;
  localparam int DB_DW      = 32;
  localparam int DB_GRP_LSB = 12;
  localparam logic [DB_GRP_LSB-1:0] DB_INC_OFF  = 12'h038;
  localparam logic [DB_GRP_LSB-1:0] DB_MASK_OFF = 12'h000;

  typedef logic [DB_TW-1:0] cnt_t;

  function automatic cnt_t cnt_add(cnt_t a, cnt_t b);
    return a + b;
  endfunction

  function automatic cnt_t cnt_pend(cnt_t tail, cnt_t head);
    return tail - head;
  endfunction
endpackage

// File: rtl/db_decode.sv
module db_decode import db_pkg::*; #(
  parameter int NQ = DB_NQ,
  parameter int AW = DB_AW
) (
  input  logic [AW-1:0] addr,
  output logic          dir,
  output logic [NQ-1:0] q_hit,
  output logic          bc_hit,
  output logic          mask_hit
);
  localparam int GW = AW - 1 - DB_GRP_LSB;

  logic [GW-1:0]         grp;
  logic [DB_GRP_LSB-1:0] off;

  assign dir = addr[AW-1];
  assign grp = addr[AW-2:DB_GRP_LSB];
  assign off = addr[DB_GRP_LSB-1:0];

  for (genvar gi = 0; gi < NQ; gi++) begin : g_hit
    assign q_hit[gi] = (grp == GW'(gi + 1)) && (off == DB_INC_OFF);
  end

  assign bc_hit   = (grp == '0) && (off == DB_INC_OFF);
  assign mask_hit = (grp == '0) && (off == DB_MASK_OFF);
endmodule

// File: rtl/db_queue.sv
module db_queue import db_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_en,
  input  cnt_t inc_val,
  input  cnt_t head,
  output cnt_t tail,
  output cnt_t pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tail <= '0;
    else if (inc_en) tail <= cnt_add(tail, inc_val);
  end

  assign pend = cnt_pend(tail, head);

  // R2 / R5: an increment advances the tail by exactly the count, modulo 2^24
  a_r2_tail_adds: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> tail == cnt_add($past(tail), $past(inc_val)));

  // R11: without an increment the tail holds
  a_r11_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_en |=> $stable(tail));
endmodule

// File: rtl/db_direction.sv
module db_direction import db_pkg::*; #(
  parameter int NQ     = DB_NQ,
  parameter bit RW_INC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [NQ-1:0]    q_hit,
  input  logic             bc_hit,
  input  logic             mask_hit,
  input  cnt_t             inc,
  input  logic [NQ*DB_TW-1:0] head_flat,
  output logic [NQ*DB_TW-1:0] tail_flat,
  output logic [NQ*DB_TW-1:0] pend_flat,
  output logic [NQ*DB_TW-1:0] last_flat,
  output logic [NQ-1:0]    mask
);
  logic [NQ-1:0] inc_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             mask <= '0;
    else if (wr && mask_hit) mask <= inc[NQ-1:0];
  end

  for (genvar qi = 0; qi < NQ; qi++) begin : g_q
    assign inc_vec[qi] = wr && (q_hit[qi] || (bc_hit && mask[qi]));

    db_queue u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (inc_vec[qi]),
      .inc_val (inc),
      .head    (head_flat[qi*DB_TW +: DB_TW]),
      .tail    (tail_flat[qi*DB_TW +: DB_TW]),
      .pend    (pend_flat[qi*DB_TW +: DB_TW])
    );

    if (RW_INC) begin : g_rw
      cnt_t last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                last_q <= '0;
        else if (wr && q_hit[qi])  last_q <= inc;
      end
      assign last_flat[qi*DB_TW +: DB_TW] = last_q;
    end else begin : g_wo
      assign last_flat[qi*DB_TW +: DB_TW] = '0;
    end
  end

  // R11: the decoder names at most one target
  a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_hit, bc_hit, mask_hit}));

  // R2 / R3: a direct doorbell write moves at most one queue
  a_r2_direct_one_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !bc_hit) |-> $onehot0(inc_vec));

  // R9: a broadcast moves exactly as many queues as the mask selects
  a_r9_bc_group_size: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bc_hit) |-> $countones(inc_vec) == $countones(mask));
endmodule

// File: rtl/db_bank.sv
module db_bank import db_pkg::*; #(
  parameter int NQ = DB_NQ,
  parameter int AW = DB_AW,
  parameter int DW = DB_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NQ*DB_TW-1:0]  head_out_i,
  input  logic [NQ*DB_TW-1:0]  head_in_i,
  output logic [NQ*DB_TW-1:0]  tail_out_o,
  output logic [NQ*DB_TW-1:0]  pend_out_o,
  output logic [NQ*DB_TW-1:0]  tail_in_o,
  output logic [NQ*DB_TW-1:0]  pend_in_o
);
  logic          dir, bc_hit, mask_hit;
  logic [NQ-1:0] q_hit;
  logic [NQ-1:0] out_mask, in_mask;
  logic [NQ*DB_TW-1:0] out_last, in_last;
  logic [DW-1:0] rd_val;
  cnt_t          inc;

  assign inc = bus_wdata[DB_TW-1:0];

  db_decode #(.NQ(NQ), .AW(AW)) u_decode (
    .addr(bus_addr), .dir(dir), .q_hit(q_hit), .bc_hit(bc_hit), .mask_hit(mask_hit)
  );

  db_direction #(.NQ(NQ), .RW_INC(1'b1)) u_out (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr && !dir),
    .q_hit(q_hit), .bc_hit(bc_hit), .mask_hit(mask_hit), .inc(inc),
    .head_flat(head_out_i), .tail_flat(tail_out_o), .pend_flat(pend_out_o),
    .last_flat(out_last), .mask(out_mask)
  );

  db_direction #(.NQ(NQ), .RW_INC(1'b0)) u_in (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr && dir),
    .q_hit(q_hit), .bc_hit(bc_hit), .mask_hit(mask_hit), .inc(inc),
    .head_flat(head_in_i), .tail_flat(tail_in_o), .pend_flat(pend_in_o),
    .last_flat(in_last), .mask(in_mask)
  );

  always_comb begin
    rd_val = '0;
    if (mask_hit) rd_val = DW'(dir ? in_mask : out_mask);
    for (int i = 0; i < NQ; i++) begin
      if (q_hit[i]) rd_val = DW'(dir ? in_last[i*DB_TW +: DB_TW] : out_last[i*DB_TW +: DB_TW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  // R7: inbound doorbells read back as zero
  a_r7_inbound_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dir && (|q_hit)) |=> bus_rdata == '0);

  // R11: reads of undecoded addresses return zero
  a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !(|q_hit) && !bc_hit && !mask_hit) |=> bus_rdata == '0);
endmodule

// File: tb/db_bank_tb.sv
module db_bank_tb;
  localparam int NQ = 16;
  localparam int TW = 24;
  localparam int M24 = 32'hFFFFFF;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [17:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NQ*TW-1:0] head_out_i = '0, head_in_i = '0;
  logic [NQ*TW-1:0] tail_out_o, pend_out_o, tail_in_o, pend_in_o;

  db_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .head_out_i(head_out_i), .head_in_i(head_in_i),
    .tail_out_o(tail_out_o), .pend_out_o(pend_out_o),
    .tail_in_o(tail_in_o), .pend_in_o(pend_in_o)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int unsigned m_out[NQ], m_in[NQ], h_out[NQ], h_in[NQ];
  int unsigned m_mask_out = 0, m_mask_in = 0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];
  logic rd_seen = 0;

  function automatic logic [17:0] q_addr(bit inb, int q);
    return 18'((inb ? 32'h20000 : 0) + 32'h1038 + q * 32'h1000);
  endfunction

  task automatic bus_write(logic [17:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(logic [17:0] a, logic [31:0] exp, string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 0;
  endtask

  // monitor: pops the scoreboard when read data is due
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      tests++;
      if (bus_rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  function automatic int unsigned add24(int unsigned a, int unsigned b);
    return (a + (b & M24)) & M24;
  endfunction

  task automatic check_tails(string tag);
    int bad = 0;
    tests++;
    for (int q = 0; q < NQ; q++) begin
      if (tail_out_o[q*TW +: TW] !== TW'(m_out[q])) begin
        bad++;
        $display("FAIL %s: out tail %0d=%h expected %h", tag, q, tail_out_o[q*TW +: TW], m_out[q]);
      end
      if (tail_in_o[q*TW +: TW] !== TW'(m_in[q])) begin
        bad++;
        $display("FAIL %s: in tail %0d=%h expected %h", tag, q, tail_in_o[q*TW +: TW], m_in[q]);
      end
    end
    if (bad != 0) fails++;
  endtask

  task automatic check_pend(string tag);
    int bad = 0;
    tests++;
    for (int q = 0; q < NQ; q++) begin
      int unsigned eo, ei;
      eo = (m_out[q] + (32'h1000000 - h_out[q])) % 32'h1000000;
      ei = (m_in[q]  + (32'h1000000 - h_in[q]))  % 32'h1000000;
      if (pend_out_o[q*TW +: TW] !== TW'(eo)) begin
        bad++;
        $display("FAIL %s: out pend %0d=%h expected %h", tag, q, pend_out_o[q*TW +: TW], eo);
      end
      if (pend_in_o[q*TW +: TW] !== TW'(ei)) begin
        bad++;
        $display("FAIL %s: in pend %0d=%h expected %h", tag, q, pend_in_o[q*TW +: TW], ei);
      end
    end
    if (bad != 0) fails++;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin m_out[q] = 0; m_in[q] = 0; h_out[q] = 0; h_in[q] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check_tails("R1 reset tails");
    check_pend("R1 reset pending");
    tests++;
    if (bus_rdata !== 32'h0) begin fails++; $display("FAIL R1: rdata=%h expected 0", bus_rdata); end
    bus_read(18'h00000, 32'h0, "R1 out mask reset");
    bus_read(18'h20000, 32'h0, "R1 in mask reset");

    // R2: outbound doorbells
    bus_write(q_addr(0, 3), 32'd5);          m_out[3]  = add24(m_out[3], 5);
    check_tails("R2 out q3");
    bus_write(q_addr(0, 15), 32'h00ABCDEF);  m_out[15] = add24(m_out[15], 32'hABCDEF);
    check_tails("R2 out q15");
    bus_write(q_addr(0, 0), 32'd1);          m_out[0]  = add24(m_out[0], 1);
    check_tails("R2 out q0");

    // R3: inbound doorbells
    bus_write(q_addr(1, 0), 32'd7);          m_in[0]   = add24(m_in[0], 7);
    check_tails("R3 in q0");
    bus_write(q_addr(1, 15), 32'd300);       m_in[15]  = add24(m_in[15], 300);
    check_tails("R3 in q15");

    // R4: reserved upper data bits ignored
    bus_write(q_addr(0, 5), 32'hFF000002);   m_out[5]  = add24(m_out[5], 2);
    check_tails("R4 out q5 reserved bits");
    bus_write(q_addr(1, 9), 32'hA5000010);   m_in[9]   = add24(m_in[9], 32'h10);
    check_tails("R4 in q9 reserved bits");

    // R5: wrap modulo 2^24
    bus_write(q_addr(0, 15), 32'h00FFFFFF);  m_out[15] = add24(m_out[15], 32'hFFFFFF);
    check_tails("R5 out q15 wrap");

    // R6: outbound doorbell readback
    bus_read(q_addr(0, 5),  32'h2,      "R6 out q5 last count");
    bus_read(q_addr(0, 15), 32'hFFFFFF, "R6 out q15 last count");
    bus_read(q_addr(0, 7),  32'h0,      "R6 out q7 never written");

    // R7: inbound doorbells write-only
    bus_read(q_addr(1, 0),  32'h0, "R7 in q0 reads zero");
    bus_read(q_addr(1, 15), 32'h0, "R7 in q15 reads zero");

    // R8: group masks
    bus_write(18'h00000, 32'hFFFF8421);      m_mask_out = 32'h8421;
    bus_write(18'h20000, 32'h000000F0);      m_mask_in  = 32'h00F0;
    bus_read(18'h00000, 32'h8421, "R8 out mask readback");
    bus_read(18'h20000, 32'h00F0, "R8 in mask readback");
    check_tails("R8 mask write leaves tails");

    // R9: broadcast
    bus_write(18'h00038, 32'd10);
    for (int q = 0; q < NQ; q++) if (m_mask_out[q]) m_out[q] = add24(m_out[q], 10);
    check_tails("R9 out broadcast");
    bus_write(18'h20038, 32'h07000003);
    for (int q = 0; q < NQ; q++) if (m_mask_in[q]) m_in[q] = add24(m_in[q], 3);
    check_tails("R9 in broadcast");
    bus_read(q_addr(0, 5), 32'h2, "R9 broadcast keeps out q5 last count");

    // R10: pending against head inputs, including head ahead of tail
    for (int q = 0; q < NQ; q++) begin
      h_out[q] = (q * 32'h3) & M24;
      h_in[q]  = (q * 32'h11 + 32'hFFFFF0) & M24;
    end
    @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      head_out_i[q*TW +: TW] = TW'(h_out[q]);
      head_in_i[q*TW +: TW]  = TW'(h_in[q]);
    end
    #1;
    check_pend("R10 pending counts");

    // R11: unmapped writes and reads
    bus_write(18'h04000, 32'd99);
    bus_write(18'h11038, 32'd99);
    bus_write(18'h2503C, 32'd99);
    check_tails("R11 unmapped writes");
    bus_read(18'h00000, 32'h8421, "R11 out mask unchanged");
    bus_read(18'h04000, 32'h0, "R11 unmapped read");
    bus_read(18'h11038, 32'h0, "R11 group 17 read");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule